// File: doc/BRIEF.md
# Host-Drained Receive Buffer Window

This block holds received bytes in a circular store that the host reads as a flat memory window. Window byte offset k always returns the k-th oldest unread byte, so the host never needs to track the internal read position. The receiver side presents one byte at a time on a valid strobe. The host reads the fill count, copies bytes from the window, and then writes the number of bytes it consumed. That single write retires those bytes and frees their space.

The window can present at most a fixed number of bytes. The last word of the address range is not readable, so with the defaults at most 1020 bytes are visible even when more are stored. The block raises two indications. The level indication is set while the fill is at or above a programmable trigger. The idle indication is set when stored data has seen no arrival and no acknowledge for a programmed number of clock periods. That period is the timeout value times the baud divider times 4.

Top module: `rx_window_buf`

## Requirements
- R1: After reset the fill count, visible count, level indication, idle indication and overrun flag are all 0.
- R2: Each byte presented with rx_valid while the fill is below capacity is stored and raises the fill by one, and arrival order is preserved.
- R3: Capacity is DEPTH-1 bytes (1023 by default). A byte arriving while the fill equals capacity is dropped and sets the sticky overrun flag. Any acknowledge write clears that flag unless a byte is dropped in the same cycle.
- R4: The visible count equals the smaller of the fill and WIN_BYTES (1020 by default).
- R5: An acknowledge write of n bytes, with n no larger than the fill, lowers the fill by n. Window offset 0 then returns the byte that was at offset n.
- R6: An acknowledge count larger than the fill is clamped to the fill, which leaves the buffer empty.
- R7: A push and an acknowledge in the same cycle both take effect: the fill becomes fill - n + 1. Acceptance of the push is decided on the fill before the acknowledge.
- R8: The level indication is high whenever fill >= 2^(lvl+2), where lvl is the 3-bit trigger input: 0 gives 4 bytes, 6 gives 256 and 7 gives 512.
- R9: With data stored, the idle indication rises exactly L = tmo*baud*4 clock cycles after the last push or acknowledge. A push or acknowledge clears it in the next cycle.
- R10: A timeout write with a non-zero value replaces the timeout value. A write of zero leaves the current value unchanged. After reset the value is DEF_TMO (4 by default).
- R11: Stored positions wrap modulo DEPTH, so the window stays in order across the end of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receiver byte strobe |
| rx_byte | input | 8 | Received byte |
| win_addr | input | AW (10) | Window byte offset from oldest unread byte |
| win_rdata | output | 8 | Byte at window offset (combinational) |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_count | input | CNT_W (10) | Number of bytes consumed |
| trig_lvl | input | 3 | Level trigger select, threshold 2^(lvl+2) |
| baud_div | input | BAUD_W (8) | Baud divider used in the idle period |
| tmo_we | input | 1 | Timeout value write strobe |
| tmo_wdata | input | TMO_W (8) | Timeout value, zero ignored |
| fill_count | output | CNT_W (10) | Bytes stored |
| win_avail | output | CNT_W (10) | Bytes visible in the window |
| level_irq | output | 1 | Fill at or above trigger |
| idle_irq | output | 1 | Character timeout indication |
| overrun | output | 1 | Sticky dropped-byte flag |

## Verification
Directed sequences cover the following cases. Short bursts with partial acknowledges show whether the window re-bases on the oldest byte. An oversized acknowledge separates clamping from wraparound of the fill. Pushing 1024 bytes separates the capacity limit, the overrun flag and the 1020-byte visible limit. The idle period is timed one cycle either side of L, under the reset timeout, a written timeout and an ignored zero write. This catches an off-by-one in the period and a zero write that is wrongly taken. A seeded random mix of pushes, acknowledges and simultaneous pairs is compared each cycle against a queue model at random window offsets, which exposes pointer and wraparound errors.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    // unreadable tail of the window, in bytes
    localparam int unsigned WIN_TAIL_BYTES = 4;
    localparam int unsigned LVL_BASE_SHIFT = 2;
endpackage

// File: rtl/rxw_ram.sv
module rxw_ram #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxw_idle_timer.sv
module rxw_idle_timer #(
    parameter int unsigned TMO_W   = 8,
    parameter int unsigned BAUD_W  = 8,
    parameter logic [TMO_W-1:0] DEF_TMO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              activity,
    input  logic              has_data,
    input  logic              tmo_we,
    input  logic [TMO_W-1:0]  tmo_wdata,
    input  logic [BAUD_W-1:0] baud_div,
    output logic              idle_irq
);
    localparam int unsigned LIM_W = TMO_W + BAUD_W + 2;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic [LIM_W-1:0] idle;
        logic             hit;
    } tmr_t;

    tmr_t s_q, s_d;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] idle_inc;

    always_comb begin
        limit    = (LIM_W'(s_q.tmo) * LIM_W'(baud_div)) << 2;
        idle_inc = s_q.idle + 1'b1;
        s_d      = s_q;
        if (tmo_we && (tmo_wdata != '0)) s_d.tmo = tmo_wdata;
        if (activity || !has_data) begin
            s_d.idle = '0;
            s_d.hit  = 1'b0;
        end else if (!s_q.hit) begin
            s_d.idle = idle_inc;
            s_d.hit  = (idle_inc >= limit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.tmo  <= DEF_TMO;
            s_q.idle <= '0;
            s_q.hit  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle_irq = s_q.hit;
endmodule

// File: rtl/rx_window_buf.sv
module rx_window_buf #(
    parameter int unsigned DEPTH     = 1024,
    parameter int unsigned WIN_BYTES = 1024 - rxw_pkg::WIN_TAIL_BYTES,
    parameter int unsigned TMO_W     = 8,
    parameter int unsigned BAUD_W    = 8,
    parameter logic [TMO_W-1:0] DEF_TMO = 4,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned CNT_W    = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [AW-1:0]     win_addr,
    output logic [7:0]        win_rdata,
    input  logic              ack_we,
    input  logic [CNT_W-1:0]  ack_count,
    input  logic [2:0]        trig_lvl,
    input  logic [BAUD_W-1:0] baud_div,
    input  logic              tmo_we,
    input  logic [TMO_W-1:0]  tmo_wdata,
    output logic [CNT_W-1:0]  fill_count,
    output logic [CNT_W-1:0]  win_avail,
    output logic              level_irq,
    output logic              idle_irq,
    output logic              overrun
);
    localparam logic [CNT_W-1:0] CAP     = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WIN_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] fill;
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic             ovr;
    } buf_t;

    buf_t s_q, s_d;
    logic             push_ok;
    logic             push_drop;
    logic [CNT_W-1:0] ack_eff;
    logic [CNT_W:0]   lvl_thresh;

    always_comb begin
        push_ok   = rx_valid && (s_q.fill != CAP);
        push_drop = rx_valid && (s_q.fill == CAP);
        ack_eff   = '0;
        if (ack_we) ack_eff = (ack_count > s_q.fill) ? s_q.fill : ack_count;

        s_d        = s_q;
        s_d.fill   = s_q.fill - ack_eff + CNT_W'(push_ok);
        s_d.wr_ptr = s_q.wr_ptr + AW'(push_ok);
        s_d.rd_ptr = s_q.rd_ptr + AW'(ack_eff);
        if (push_drop)   s_d.ovr = 1'b1;
        else if (ack_we) s_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rxw_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (push_ok),
        .waddr (s_q.wr_ptr),
        .wdata (rx_byte),
        .raddr (s_q.rd_ptr + win_addr),
        .rdata (win_rdata)
    );

    rxw_idle_timer #(.TMO_W(TMO_W), .BAUD_W(BAUD_W), .DEF_TMO(DEF_TMO)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .activity  (rx_valid || ack_we),
        .has_data  (s_q.fill != '0),
        .tmo_we    (tmo_we),
        .tmo_wdata (tmo_wdata),
        .baud_div  (baud_div),
        .idle_irq  (idle_irq)
    );

    always_comb begin
        lvl_thresh = (CNT_W+1)'(1) << (trig_lvl + rxw_pkg::LVL_BASE_SHIFT);
        level_irq  = ({1'b0, s_q.fill} >= lvl_thresh);
        win_avail  = (s_q.fill > WIN_LIM) ? WIN_LIM : s_q.fill;
    end

    assign fill_count = s_q.fill;
    assign overrun    = s_q.ovr;
endmodule

// File: rtl/rx_window_buf_chk.sv
module rx_window_buf_chk #(
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned CAP       = 1023,
    parameter int unsigned WIN_BYTES = 1020
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             ack_we,
    input logic [CNT_W-1:0] ack_count,
    input logic [CNT_W-1:0] fill_count,
    input logic [CNT_W-1:0] win_avail,
    input logic             idle_irq,
    input logic             overrun
);
    p_fill_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(CAP));

    p_drop_sets_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fill_count == CNT_W'(CAP)) |=> overrun);

    p_avail_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_avail <= CNT_W'(WIN_BYTES)) && (win_avail <= fill_count));

    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ack_we && fill_count < CNT_W'(CAP))
        |=> fill_count == CNT_W'($past(fill_count) + 1'b1));

    p_ack_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !rx_valid && ack_count >= fill_count) |=> fill_count == '0);

    p_idle_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_irq |-> fill_count != '0);

    p_push_clears_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || ack_we) |=> !idle_irq);
endmodule

bind rx_window_buf rx_window_buf_chk #(
    .CNT_W(CNT_W), .CAP(DEPTH - 1), .WIN_BYTES(WIN_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .ack_we     (ack_we),
    .ack_count  (ack_count),
    .fill_count (fill_count),
    .win_avail  (win_avail),
    .idle_irq   (idle_irq),
    .overrun    (overrun)
);

// File: tb/sim_rx_window_buf.sv
`timescale 1ns/1ps
module sim_rx_window_buf;
    localparam int CAP = 1023;
    localparam int WIN = 1020;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [9:0] win_addr = '0;
    logic [7:0] win_rdata;
    logic       ack_we = 1'b0;
    logic [9:0] ack_count = '0;
    logic [2:0] trig_lvl = '0;
    logic [7:0] baud_div = 8'd200;
    logic       tmo_we = 1'b0;
    logic [7:0] tmo_wdata = '0;
    logic [9:0] fill_count, win_avail;
    logic       level_irq, idle_irq, overrun;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] q[$];
    bit m_ovr = 0;

    always #2 clk = ~clk;

    rx_window_buf u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .win_addr(win_addr), .win_rdata(win_rdata), .ack_we(ack_we),
        .ack_count(ack_count), .trig_lvl(trig_lvl), .baud_div(baud_div),
        .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .fill_count(fill_count),
        .win_avail(win_avail), .level_irq(level_irq), .idle_irq(idle_irq),
        .overrun(overrun)
    );

    function automatic int exp_avail(int f);
        return (f > WIN) ? WIN : f;
    endfunction

    function automatic int exp_level(int f, int lvl);
        return (f >= (1 << (lvl + 2))) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock with optional push and acknowledge, model updated after
    task automatic cyc(input bit p, input logic [7:0] b, input bit a, input int n);
        bit full_before;
        int k;
        rx_valid = p; rx_byte = b; ack_we = a; ack_count = n[9:0];
        @(posedge clk); #1;
        rx_valid = 0; ack_we = 0;
        full_before = (q.size() >= CAP);
        if (a) begin
            k = (n > q.size()) ? q.size() : n;
            for (int i = 0; i < k; i++) void'(q.pop_front());
        end
        if (p && full_before) m_ovr = 1;
        else if (a) m_ovr = 0;
        if (p && !full_before) q.push_back(b);
    endtask

    task automatic chk_state(input string req);
        chk({req, " fill"}, int'(fill_count), q.size());
        chk({"R4 avail"}, int'(win_avail), exp_avail(q.size()));
        chk({"R3 overrun"}, int'(overrun), int'(m_ovr));
    endtask

    task automatic chk_byte(input string req, input int k);
        win_addr = k[9:0]; #0.5;
        chk(req, int'(win_rdata), int'(q[k]));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 fill", int'(fill_count), 0);
        chk("R1 avail", int'(win_avail), 0);
        chk("R1 level", int'(level_irq), 0);
        chk("R1 idle", int'(idle_irq), 0);
        chk("R1 overrun", int'(overrun), 0);

        // R2 push order
        for (int i = 0; i < 5; i++) cyc(1, 8'hA0 + 8'(i), 0, 0);
        chk_state("R2");
        for (int i = 0; i < 5; i++) chk_byte("R2 window byte", i);

        // R8 level trigger
        trig_lvl = 3'd0; #0.5;
        chk("R8 lvl0 fill5", int'(level_irq), 1);
        trig_lvl = 3'd1; #0.5;
        chk("R8 lvl1 fill5", int'(level_irq), 0);

        // R5 partial acknowledge
        cyc(0, 0, 1, 2);
        chk_state("R5");
        chk_byte("R5 rebased byte0", 0);
        chk("R5 byte0 value", int'(win_rdata), 8'hA2);

        // R7 push and acknowledge together
        cyc(1, 8'h55, 1, 1);
        chk_state("R7");
        chk("R7 fill", int'(fill_count), 3);
        chk_byte("R7 byte0", 0);
        chk_byte("R7 newest", 2);

        // R6 oversized acknowledge
        cyc(0, 0, 1, 100);
        chk("R6 clamp fill", int'(fill_count), 0);

        // R9 idle timing with default timeout 4, baud 3: L = 48
        baud_div = 8'd3;
        cyc(1, 8'h11, 0, 0);
        idle(47);
        chk("R9 idle before L", int'(idle_irq), 0);
        idle(1);
        chk("R9 idle at L", int'(idle_irq), 1);
        cyc(1, 8'h12, 0, 0);
        chk("R9 push clears idle", int'(idle_irq), 0);
        idle(48);
        chk("R9 idle again", int'(idle_irq), 1);
        cyc(0, 0, 1, 1);
        chk("R9 ack clears idle", int'(idle_irq), 0);

        // R10 timeout write 2 -> L = 24, then zero write ignored
        tmo_we = 1; tmo_wdata = 8'd2; @(posedge clk); #1; tmo_we = 0;
        cyc(1, 8'h13, 0, 0);
        idle(23);
        chk("R10 new tmo before", int'(idle_irq), 0);
        idle(1);
        chk("R10 new tmo at L", int'(idle_irq), 1);
        tmo_we = 1; tmo_wdata = 8'd0; @(posedge clk); #1; tmo_we = 0;
        cyc(1, 8'h14, 0, 0);
        idle(23);
        chk("R10 zero write kept", int'(idle_irq), 0);
        idle(1);
        chk("R10 zero write kept at L", int'(idle_irq), 1);
        cyc(0, 0, 1, 1023);
        baud_div = 8'd200;

        // R3 / R4 capacity and overrun
        for (int i = 0; i < CAP + 1; i++) cyc(1, 8'(i * 7 + 3), 0, 0);
        chk_state("R3");
        chk("R3 overrun set", int'(overrun), 1);
        chk("R4 avail capped", int'(win_avail), WIN);
        trig_lvl = 3'd7; #0.5;
        chk("R8 lvl7 full", int'(level_irq), 1);
        chk_byte("R4 last visible", WIN - 1);
        cyc(0, 0, 1, 0);
        chk("R3 ack clears overrun", int'(overrun), 0);
        chk("R3 ack0 keeps fill", int'(fill_count), CAP);

        // R11 wraparound
        cyc(0, 0, 1, 1000);
        for (int i = 0; i < 500; i++) cyc(1, 8'(i ^ 8'h3C), 0, 0);
        chk_state("R11");
        for (int i = 0; i < q.size(); i += 37) chk_byte("R11 wrapped byte", i);
        trig_lvl = 3'd6; #0.5;
        chk("R8 lvl6", int'(level_irq), exp_level(q.size(), 6));

        // random mix
        for (int t = 0; t < 3000; t++) begin
            bit p, a;
            int n;
            p = ($urandom % 4) != 0;
            a = ($urandom % 6) == 0;
            n = $urandom % 64;
            cyc(p, 8'($urandom), a, n);
            chk("R2 random fill", int'(fill_count), q.size());
            chk("R4 random avail", int'(win_avail), exp_avail(q.size()));
            if (q.size() > 0) chk_byte("R11 random byte", $urandom % exp_avail(q.size()));
            trig_lvl = 3'($urandom); #0.5;
            chk("R8 random level", int'(level_irq), exp_level(q.size(), int'(trig_lvl)));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule